// File: doc/BRIEF.md
# Enable-Strobed Memory Cycle Sequencer

This block sits between a simple host request port and a one-bit-wide static memory that latches its address when its active-low enable falls and that is written while enable and write-enable are both low. The host raises a request with a direction, a 10-bit address, a write bit, a burst flag and a shared-bus flag. The sequencer then produces the whole memory cycle: address presentation, the enable-low window, the write-enable pulse, the data-bus drive window and the enable-high recovery. It answers with a one-cycle acknowledge that carries the read data.

Every minimum interval is given in nanoseconds as a parameter. It is turned into a whole number of clock cycles by rounding up against a clock-period parameter. With the default 4 ns clock, the enable-low window is 46 cycles for a read, 45 cycles for a write on a split data bus and 50 cycles for a write on a shared bus. Recovery lasts 25 cycles. Burst writes keep write-enable low from one cycle to the next, so only the rising edge of enable ends each write. On a shared bus, write data is not driven until the memory's output-disable time has passed after write-enable fell.

Top module: `strobe_mem_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, memEnN and memWeN are 1, and memDrive and reqAck are 0.
- R2: memAddr shows the accepted request address from the cycle after acceptance, which is one full cycle before memEnN falls, and it does not change while memEnN is 0.
- R3: memEnN stays 0 for exactly L cycles. For a read, L = max(ceil(T_ENLOW), ceil(T_ACCESS)+1). For a write, L = max(ceil(T_ENLOW), ceil(T_WEPULSE), ceil(T_WESETUP), ceil(T_WEHOLD), S+ceil(T_DSETUP)), where S is the drive start from R9. Each ceil is taken in clock cycles.
- R4: Once memEnN rises, it stays 1 for at least ceil(T_ENHIGH) cycles. Two falling edges of memEnN are at least ceil(T_CYCLE) cycles apart.
- R5: For a read, rspRdata equals the memQ value at the clock edge that ends the last enable-low cycle. That edge is at least ceil(T_ACCESS)+1 cycles after enable fell.
- R6: The sequencer stays in recovery for K+1 cycles, where K is the smallest number with K+1 >= ceil(T_ENHIGH) and L+K+4 >= ceil(T_CYCLE). reqAck is then 1 for exactly one cycle, after which the sequencer goes back to idle.
- R7: In a write that is not preceded by a held burst, memWeN falls in the same cycle as memEnN and rises with it. memDin equals the request write bit whenever memDrive is 1. The memory therefore stores that bit at the rising edge of memEnN.
- R8: A write with reqBurst=1 leaves memWeN at 0 after memEnN rises. It stays 0 through recovery, the acknowledge and idle, until the next request is accepted. It returns to 1 in the cycle after accepting a read or a write with reqBurst=0.
- R9: In a write, memDrive is 1 from enable-low cycle S to the end of the low window, and for one more cycle after memEnN rises. S = ceil(T_TURN) when busShared was 1 at acceptance, and S = 0 otherwise.
- R10: During a read, memWeN is 1 and memDrive is 0 for the whole enable-low window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; held until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | Keep write-enable low after this write |
| busShared | input | 1 | Memory data in and out share one wire |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | 1 | Write data bit |
| reqAck | output | 1 | One-cycle completion pulse |
| rspRdata | output | 1 | Read data, valid with reqAck |
| memEnN | output | 1 | Memory enable, active low |
| memWeN | output | 1 | Memory write-enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDin | output | 1 | Memory data input |
| memDrive | output | 1 | Drive enable for the data wire |
| memQ | input | 1 | Memory data output |

## Verification
Several properties are checked on every clock: the address holds steady under an enable-low window, each low window meets its minimum width, two enable falls are never closer than one cycle time, the acknowledge lasts a single cycle, a read never lowers write-enable or drives the bus, and shared-bus drive never starts before the turnaround count. Other behaviour can only be shown by the scenarios. These include the exact window lengths and the exact acknowledge cycle, write-enable staying low across a run of burst writes and being released by a read, and read-back of each stored bit from a bench memory. That memory returns wrong data until the access time has passed, which exposes sampling that comes too early.

// File: rtl/strobe_mem_pkg.sv
package strobe_mem_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ADDR  = 3'd1,
    S_LOW   = 3'd2,
    S_RECOV = 3'd3,
    S_DONE  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture request address and data
    logic capture;  // sample memQ into the read register
    logic drive;    // enable write data onto the memory data wire
  } seqStrobe_t;

  // round a time in ns up to whole clock cycles
  function automatic int nsToCyc(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_cycle_counter.sv
module seq_cycle_counter #(
  parameter int W = 8,
  parameter bit RESET_SAT = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= RESET_SAT ? MAXV : '0;
    end else if (clear) begin
      count <= '0;
    end else if (count != MAXV) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import strobe_mem_pkg::*;
#(
  parameter int ENLOW_C   = 45,
  parameter int ENHIGH_C  = 25,
  parameter int CYCLE_C   = 70,
  parameter int ACCESS_C  = 45,
  parameter int WEPULSE_C = 25,
  parameter int WESETUP_C = 25,
  parameter int WEHOLD_C  = 25,
  parameter int DSETUP_C  = 20,
  parameter int TURN_C    = 30,
  parameter int CNT_W     = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqBurst,
  input  logic       busShared,
  output logic       reqAck,
  output logic       memEnN,
  output logic       memWeN,
  output seqStrobe_t strobe
);

  localparam int RD_LOW  = imax(ENLOW_C, ACCESS_C + 1);
  localparam int WR_BASE = imax(imax(ENLOW_C, WEPULSE_C), imax(WESETUP_C, WEHOLD_C));
  localparam int WR_LOW  = imax(WR_BASE, DSETUP_C);
  localparam int WS_LOW  = imax(WR_BASE, TURN_C + DSETUP_C);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_LOW - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_LOW - 1);
  localparam logic [CNT_W-1:0] WS_LAST = CNT_W'(WS_LOW - 1);
  localparam logic [CNT_W-1:0] TURN_V  = CNT_W'(TURN_C);
  localparam logic [CNT_W:0]   HIGH_V  = (CNT_W+1)'(ENHIGH_C);
  localparam logic [CNT_W:0]   CYC_V   = (CNT_W+1)'(CYCLE_C);
  localparam logic [CNT_W:0]   ENLOW_V = (CNT_W+1)'(ENLOW_C);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] phaseCnt, sinceFall, lowLast, driveStart;
  logic             curWrite, curBurst, curShared, weHeld;
  logic             accept, lowDone, recovDone;

  seq_cycle_counter #(.W(CNT_W), .RESET_SAT(1'b0)) uPhase (
    .clk(clk), .rstN(rstN), .clear(stateNext != state), .count(phaseCnt)
  );

  seq_cycle_counter #(.W(CNT_W), .RESET_SAT(1'b1)) uFall (
    .clk(clk), .rstN(rstN), .clear(state == S_ADDR), .count(sinceFall)
  );

  assign accept     = (state == S_IDLE) && reqValid;
  assign lowLast    = !curWrite ? RD_LAST : (curShared ? WS_LAST : WR_LAST);
  assign driveStart = curShared ? TURN_V : '0;
  assign lowDone    = (state == S_LOW) && (phaseCnt == lowLast);
  assign recovDone  = (({1'b0, phaseCnt} + 1'b1) >= HIGH_V) &&
                      (({1'b0, sinceFall} + (CNT_W+1)'(4)) >= CYC_V);

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (reqValid) stateNext = S_ADDR;
      S_ADDR:  stateNext = S_LOW;
      S_LOW:   if (lowDone) stateNext = S_RECOV;
      S_RECOV: if (recovDone) stateNext = S_DONE;
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      curWrite  <= 1'b0;
      curBurst  <= 1'b0;
      curShared <= 1'b0;
      weHeld    <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        curWrite  <= reqWrite;
        curBurst  <= reqBurst;
        curShared <= busShared;
        if (!(reqWrite && reqBurst)) weHeld <= 1'b0;
      end
      if (lowDone && curWrite && curBurst) weHeld <= 1'b1;
    end
  end

  assign memEnN = (state != S_LOW);
  assign memWeN = !(((state == S_LOW) && curWrite) || weHeld);
  assign reqAck = (state == S_DONE);

  assign strobe.load    = accept;
  assign strobe.capture = lowDone && !curWrite;
  assign strobe.drive   = curWrite &&
                          (((state == S_LOW) && (phaseCnt >= driveStart)) ||
                           ((state == S_RECOV) && (phaseCnt == '0)));

  // R3: enable-low window meets its minimum width
  a_r3_low_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memEnN) |-> (({1'b0, $past(phaseCnt)} + 1'b1) >= ENLOW_V));

  // R4: enable fall-to-fall spacing
  a_r4_cycle_time: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memEnN) |-> (({1'b0, $past(sinceFall)} + 1'b1) >= CYC_V));

  // R6: acknowledge lasts one cycle
  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R10: reads never lower write-enable nor drive the wire
  a_r10_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!memEnN && !curWrite) |-> (memWeN && !strobe.drive));

  // R9: shared-bus drive waits for the turnaround count
  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drive && !memEnN && curShared) |-> (phaseCnt >= TURN_V));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import strobe_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWdata,
  input  logic              memQ,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memDin,
  output logic              memDrive,
  output logic              rspRdata
);

  logic [ADDR_W-1:0] addrReg;
  logic              wdataReg, rdataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= 1'b0;
      rdataReg <= 1'b0;
    end else begin
      if (strobe.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strobe.capture) rdataReg <= memQ;
    end
  end

  assign memAddr  = addrReg;
  assign memDin   = wdataReg;
  assign memDrive = strobe.drive;
  assign rspRdata = rdataReg;

  // R7: write data is steady while it is driven
  a_r7_din_steady: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drive && $past(strobe.drive)) |-> $stable(memDin));

endmodule

// File: rtl/strobe_mem_seq.sv
module strobe_mem_seq
  import strobe_mem_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int CLK_NS     = 4,
  parameter int T_ENLOW    = 180,
  parameter int T_ENHIGH   = 100,
  parameter int T_CYCLE    = 280,
  parameter int T_ACCESS   = 180,
  parameter int T_WEPULSE  = 100,
  parameter int T_WESETUP  = 100,
  parameter int T_WEHOLD   = 100,
  parameter int T_DSETUP   = 80,
  parameter int T_TURN     = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqBurst,
  input  logic              busShared,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWdata,
  output logic              reqAck,
  output logic              rspRdata,
  output logic              memEnN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memDin,
  output logic              memDrive,
  input  logic              memQ
);

  localparam int ENLOW_C   = nsToCyc(T_ENLOW, CLK_NS);
  localparam int ENHIGH_C  = nsToCyc(T_ENHIGH, CLK_NS);
  localparam int CYCLE_C   = nsToCyc(T_CYCLE, CLK_NS);
  localparam int ACCESS_C  = nsToCyc(T_ACCESS, CLK_NS);
  localparam int WEPULSE_C = nsToCyc(T_WEPULSE, CLK_NS);
  localparam int WESETUP_C = nsToCyc(T_WESETUP, CLK_NS);
  localparam int WEHOLD_C  = nsToCyc(T_WEHOLD, CLK_NS);
  localparam int DSETUP_C  = nsToCyc(T_DSETUP, CLK_NS);
  localparam int TURN_C    = nsToCyc(T_TURN, CLK_NS);
  localparam int SPAN_C    = CYCLE_C + ENLOW_C + ENHIGH_C + ACCESS_C + WEPULSE_C +
                             WESETUP_C + WEHOLD_C + DSETUP_C + TURN_C + 8;
  localparam int CNT_W     = $clog2(SPAN_C) + 1;

  seqStrobe_t strobe;

  seq_ctrl #(
    .ENLOW_C(ENLOW_C), .ENHIGH_C(ENHIGH_C), .CYCLE_C(CYCLE_C),
    .ACCESS_C(ACCESS_C), .WEPULSE_C(WEPULSE_C), .WESETUP_C(WESETUP_C),
    .WEHOLD_C(WEHOLD_C), .DSETUP_C(DSETUP_C), .TURN_C(TURN_C), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBurst(reqBurst), .busShared(busShared), .reqAck(reqAck),
    .memEnN(memEnN), .memWeN(memWeN), .strobe(strobe)
  );

  seq_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memQ(memQ), .memAddr(memAddr), .memDin(memDin),
    .memDrive(memDrive), .rspRdata(rspRdata)
  );

  // R2: latched address holds while enable is low
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !memEnN |-> $stable(memAddr));

endmodule

// File: tb/strobe_mem_seq_test.sv
module strobe_mem_seq_test;

  localparam int CLKNS = 4;
  function automatic int cy(input int ns);
    return (ns + CLKNS - 1) / CLKNS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ENLOW  = cy(180);
  localparam int ENHIGH = cy(100);
  localparam int CYC    = cy(280);
  localparam int ACC    = cy(180);
  localparam int WEP    = cy(100);
  localparam int DSU    = cy(80);
  localparam int TURN   = cy(120);

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0, busShared = 1'b0;
  logic [9:0] reqAddr = '0;
  logic       reqWdata = 1'b0;
  logic       reqAck, rspRdata, memEnN, memWeN, memDin, memDrive;
  logic [9:0] memAddr;
  logic       memQ = 1'b0;

  always #(CLKNS/2) clk = ~clk;

  strobe_mem_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBurst(reqBurst), .busShared(busShared), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqAck(reqAck), .rspRdata(rspRdata),
    .memEnN(memEnN), .memWeN(memWeN), .memAddr(memAddr), .memDin(memDin),
    .memDrive(memDrive), .memQ(memQ)
  );

  int vectors = 0;
  int errors  = 0;

  // reference model state
  logic expEnN = 1'b1, expWeN = 1'b1, expDrive = 1'b0, expAck = 1'b0, expRd = 1'b0;
  logic mW = 1'b0, mB = 1'b0, mS = 1'b0, mD = 1'b0, heldLow = 1'b0;
  logic [9:0] mA = '0;
  logic modelMem [1024];

  // bench memory
  logic benchMem [1024];
  logic [9:0] latAddr = '0;
  logic prevEn = 1'b1, prevWe = 1'b1, prevDrive = 1'b0, prevDin = 1'b0;
  int   sinceFallB = 0;

  initial begin
    for (int i = 0; i < 1024; i++) begin
      modelMem[i] = 1'b0;
      benchMem[i] = 1'b0;
    end
  end

  // behavioural cycle model
  initial begin
    int lowLen, start;
    wait (rstN);
    forever begin
      @(posedge clk);
      if (reqValid) begin
        mW = reqWrite; mB = reqBurst; mS = busShared; mA = reqAddr; mD = reqWdata;
        if (!(mW && mB)) heldLow = 1'b0;
        start  = (mW && mS) ? TURN : 0;
        lowLen = mW ? mx(mx(ENLOW, WEP), start + DSU) : mx(ENLOW, ACC + 1);
        expEnN = 1'b1; expWeN = !heldLow; expDrive = 1'b0;
        @(posedge clk);
        for (int i = 0; i < lowLen; i++) begin
          expEnN = 1'b0; expWeN = !mW; expDrive = mW && (i >= start);
          @(posedge clk);
        end
        if (mW) modelMem[mA] = mD;
        heldLow = mW && mB;
        for (int k = 0; ; k++) begin
          expEnN = 1'b1; expWeN = !heldLow; expDrive = mW && (k == 0);
          @(posedge clk);
          if ((k + 1 >= ENHIGH) && (lowLen + k + 4 >= CYC)) break;
        end
        expAck = 1'b1; expDrive = 1'b0; expRd = modelMem[mA];
        @(posedge clk);
        expAck = 1'b0;
      end
    end
  end

  // bench memory: stores at enable rise with write-enable low; slow read data
  always @(negedge clk) begin
    if (prevEn && !memEnN) begin
      latAddr    = memAddr;
      sinceFallB = 0;
    end else if (!memEnN) begin
      sinceFallB = sinceFallB + 1;
    end
    if (!prevEn && memEnN && !prevWe) benchMem[latAddr] = prevDrive ? prevDin : 1'bx;
    if (!memEnN && memWeN && sinceFallB >= ACC) memQ = benchMem[latAddr];
    else memQ = ~benchMem[latAddr];
    prevEn = memEnN; prevWe = memWeN; prevDrive = memDrive; prevDin = memDin;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    vectors++;
    chk(rstN ? "R3/R4 memEnN" : "R1 memEnN", memEnN, expEnN);
    chk(rstN ? "R7/R8/R10 memWeN" : "R1 memWeN", memWeN, expWeN);
    chk(rstN ? "R9/R10 memDrive" : "R1 memDrive", memDrive, expDrive);
    chk(rstN ? "R6 reqAck" : "R1 reqAck", reqAck, expAck);
    if (!expEnN && memAddr !== mA) begin
      errors++;
      $display("FAIL R2 memAddr at %0t: actual %0d expected %0d", $time, memAddr, mA);
    end
    if (expDrive) chk("R7 memDin", memDin, mD);
    if (expAck && !mW) chk("R5 rspRdata", rspRdata, expRd);
  end

  task automatic doOp(input logic w, input logic b, input logic s,
                      input logic [9:0] a, input logic d);
    int guard;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqBurst = b; busShared = s; reqAddr = a; reqWdata = d;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!reqAck && guard < 2000);
    if (!reqAck) begin
      errors++;
      $display("FAIL R6 watchdog: actual no ack expected ack");
    end
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R7 / R10 / R5: split-bus write then read-back
    doOp(1'b1, 1'b0, 1'b0, 10'd0, 1'b1);
    doOp(1'b0, 1'b0, 1'b0, 10'd0, 1'b0);
    // R9: shared-bus writes and reads at the top address
    doOp(1'b1, 1'b0, 1'b1, 10'd1023, 1'b1);
    doOp(1'b0, 1'b0, 1'b1, 10'd1023, 1'b0);
    doOp(1'b1, 1'b0, 1'b1, 10'd1023, 1'b0);
    doOp(1'b0, 1'b0, 1'b0, 10'd1023, 1'b1);
    // R8: burst run, released by a read
    doOp(1'b1, 1'b1, 1'b0, 10'd5, 1'b1);
    doOp(1'b1, 1'b1, 1'b0, 10'd6, 1'b0);
    doOp(1'b1, 1'b1, 1'b1, 10'd7, 1'b1);
    repeat (20) @(negedge clk);
    doOp(1'b0, 1'b0, 1'b0, 10'd6, 1'b0);
    doOp(1'b0, 1'b0, 1'b0, 10'd5, 1'b0);
    doOp(1'b0, 1'b0, 1'b1, 10'd7, 1'b0);
    // R8: burst followed by a plain write releases write-enable
    doOp(1'b1, 1'b1, 1'b0, 10'd512, 1'b1);
    doOp(1'b1, 1'b0, 1'b0, 10'd513, 1'b1);
    doOp(1'b0, 1'b0, 1'b0, 10'd512, 1'b0);
    doOp(1'b0, 1'b0, 1'b0, 10'd513, 1'b0);
    doOp(1'b0, 1'b0, 1'b0, 10'd300, 1'b0);
    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule